// File: doc/BRIEF.md
# Eight-Bit Arithmetic Logic Unit with Compare Flags

This block is a purely combinational arithmetic logic unit for an 8-bit datapath. It takes two unsigned operands, a carry input and a 3-bit operation select. It returns an 8-bit result and four status outputs: carry out, zero, equal and A-larger. Every operation is evaluated in parallel. The decoded select then picks which value drives the result and the carry.

The surrounding datapath samples the result into an accumulator and the four status bits into a flag register. That capture lives outside this block. The block holds no state, so every output follows its present inputs alone.

Top module: `alu8_core`

## Requirements
- R1: With select 000 the result is (A + B) mod 256, and carry out is 1 exactly when A + B exceeds 255.
- R2: With select 001 the result is A shifted right by one bit, with carry_in placed in bit 7. Carry out equals the old bit 0 of A, and B has no effect on any output except equal and A-larger.
- R3: With select 010 the result is A shifted left by one bit, with carry_in placed in bit 0. Carry out equals the old bit 7 of A, and B has no effect on any output except equal and A-larger.
- R4: With select 011 the result is the bitwise complement of A, and carry out is 0.
- R5: With select 100 the result is A AND B. With select 101 the result is A OR B. Carry out is 0 for both.
- R6: With select 110 the result is A XOR B, and carry out is 0.
- R7: With select 111 the result is 0 and carry out is 0.
- R8: For every select, the zero flag is 1 exactly when the 8-bit result is 0.
- R9: For every select, the equal flag is 1 exactly when A equals B.
- R10: For every select, the A-larger flag is 1 exactly when A is greater than B as an unsigned number.
- R11: The outputs depend only on the present inputs. Applying the same inputs again gives the same outputs, whatever inputs came before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 8 | Operand A, unsigned |
| opnd_b | input | 8 | Operand B, unsigned |
| carry_in | input | 1 | Carry input, used by the two shifts |
| op_sel | input | 3 | Operation select |
| result | output | 8 | Selected result |
| carry_out | output | 1 | Carry or shifted-out bit |
| zero_flag | output | 1 | High when result is all zeros |
| equal_flag | output | 1 | High when A equals B |
| a_larger_flag | output | 1 | High when A exceeds B, unsigned |

## Verification
The sweep covers every operand A under every select and both carry-in values. Operand B is swept over the boundary values and a spread of middle values. This exposes three faults: an adder that drops the carry at 255+1, a shift that fills from zero instead of carry_in, and a shift that emits the wrong end bit as carry.

The cases where A equals B and where A and B differ by one find a compare that uses signed order or that mixes up greater-than with greater-or-equal. Operands above 127 catch a signed compare, because it inverts A-larger whenever the top bits differ.

XOR of equal operands and addition of 1 to 255 both give a zero result, which checks that the zero flag follows the result and not the operands. Select 111 must give zero with no carry, rather than a leftover operation. Repeating an earlier vector after other traffic shows that no value is held between vectors.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    typedef enum logic [2:0] {
        OP_ADD = 3'b000,
        OP_SHR = 3'b001,
        OP_SHL = 3'b010,
        OP_INV = 3'b011,
        OP_AND = 3'b100,
        OP_IOR = 3'b101,
        OP_XOR = 3'b110,
        OP_NOP = 3'b111
    } op_e;
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] add_res,
    output logic         add_co,
    output logic [W-1:0] shr_res,
    output logic         shr_co,
    output logic [W-1:0] shl_res,
    output logic         shl_co
);
    logic [W:0] sum_ext;

    assign sum_ext = {1'b0, a} + {1'b0, b};
    assign add_res = sum_ext[W-1:0];
    assign add_co  = sum_ext[W];

    // carry_in enters at the vacated end, the bit pushed out becomes carry
    assign shr_res = {cin, a[W-1:1]};
    assign shr_co  = a[0];
    assign shl_res = {a[W-2:0], cin};
    assign shl_co  = a[W-1];
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] inv_res,
    output logic [W-1:0] and_res,
    output logic [W-1:0] ior_res,
    output logic [W-1:0] xor_res
);
    assign inv_res = ~a;
    assign and_res = a & b;
    assign ior_res = a | b;
    assign xor_res = a ^ b;
endmodule

// File: rtl/alu8_cmp.sv
module alu8_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         eq,
    output logic         gt
);
    logic [W:0] diff_ext;

    // b - a borrows exactly when a > b (unsigned)
    assign diff_ext = {1'b0, b} - {1'b0, a};
    assign gt = diff_ext[W];
    assign eq = (diff_ext[W-1:0] == '0);
endmodule

// File: rtl/alu8_core.sv
module alu8_core #(
    parameter int W = 8
) (
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic         carry_in,
    input  logic [2:0]   op_sel,
    output logic [W-1:0] result,
    output logic         carry_out,
    output logic         zero_flag,
    output logic         equal_flag,
    output logic         a_larger_flag
);
    import alu8_pkg::*;

    op_e          op;
    logic [W-1:0] add_res, shr_res, shl_res;
    logic         add_co, shr_co, shl_co;
    logic [W-1:0] inv_res, and_res, ior_res, xor_res;

    assign op = op_e'(op_sel);

    alu8_arith #(.W(W)) u_arith (
        .a(opnd_a), .b(opnd_b), .cin(carry_in),
        .add_res(add_res), .add_co(add_co),
        .shr_res(shr_res), .shr_co(shr_co),
        .shl_res(shl_res), .shl_co(shl_co)
    );

    alu8_logic #(.W(W)) u_logic (
        .a(opnd_a), .b(opnd_b),
        .inv_res(inv_res), .and_res(and_res),
        .ior_res(ior_res), .xor_res(xor_res)
    );

    alu8_cmp #(.W(W)) u_cmp (
        .a(opnd_a), .b(opnd_b),
        .eq(equal_flag), .gt(a_larger_flag)
    );

    always_comb begin
        unique case (op)
            OP_ADD: begin result = add_res; carry_out = add_co; end
            OP_SHR: begin result = shr_res; carry_out = shr_co; end
            OP_SHL: begin result = shl_res; carry_out = shl_co; end
            OP_INV: begin result = inv_res; carry_out = 1'b0;   end
            OP_AND: begin result = and_res; carry_out = 1'b0;   end
            OP_IOR: begin result = ior_res; carry_out = 1'b0;   end
            OP_XOR: begin result = xor_res; carry_out = 1'b0;   end
            OP_NOP: begin result = '0;      carry_out = 1'b0;   end
        endcase
    end

    assign zero_flag = ~|result;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
    parameter int W = 8
) (
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic         carry_in,
    input logic [2:0]   op_sel,
    input logic [W-1:0] result,
    input logic         carry_out,
    input logic         zero_flag,
    input logic         equal_flag,
    input logic         a_larger_flag
);
    logic known;
    assign known = !$isunknown({opnd_a, opnd_b, carry_in, op_sel});

    always_comb begin
        if (known) begin
            AST_ZERO_TRACKS: assert (zero_flag == (result == '0)); // R8
            AST_EQ_CMP: assert (equal_flag == (opnd_a == opnd_b)); // R9
            AST_GT_CMP: assert (a_larger_flag == (opnd_a > opnd_b)); // R10
            AST_EQ_GT_EXCL: assert (!(equal_flag && a_larger_flag)); // R10
            if (op_sel == 3'b111) begin
                AST_NOP_CLEAR: assert (result == '0 && !carry_out); // R7
            end
            if (op_sel == 3'b001) begin
                AST_SHR_CARRY: assert (carry_out == opnd_a[0] && result[W-1] == carry_in); // R2
            end
            if (op_sel == 3'b010) begin
                AST_SHL_CARRY: assert (carry_out == opnd_a[W-1] && result[0] == carry_in); // R3
            end
            if (op_sel[2] || op_sel == 3'b011) begin
                AST_LOGIC_NO_CARRY: assert (!carry_out); // R4
            end
        end
    end
endmodule

bind alu8_core alu8_core_chk #(.W(W)) u_chk (.*);

// File: tb/sim_alu8_core.sv
module sim_alu8_core;
    logic       clk = 1'b0;
    logic [7:0] opnd_a, opnd_b, result;
    logic       carry_in, carry_out, zero_flag, equal_flag, a_larger_flag;
    logic [2:0] op_sel;
    int         n_chk = 0;
    int         n_bad = 0;
    int         cyc = 0;
    logic       done = 1'b0;

    always #4 clk = ~clk;

    alu8_core u0 (
        .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in), .op_sel(op_sel),
        .result(result), .carry_out(carry_out), .zero_flag(zero_flag),
        .equal_flag(equal_flag), .a_larger_flag(a_larger_flag)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d (op=%0d a=%0d b=%0d cin=%0d)",
                     tag, got, exp, op_sel, opnd_a, opnd_b, carry_in);
        end
    endtask

    task automatic apply(input int op, input int a, input int b, input int ci);
        @(negedge clk);
        op_sel = op[2:0]; opnd_a = a[7:0]; opnd_b = b[7:0]; carry_in = ci[0];
        #2;
    endtask

    task automatic check_vec(input int op, input int a, input int b, input int ci);
        int er, ec;
        ec = 0;
        case (op)
            0: begin er = (a + b) % 256; ec = (a + b) / 256; end
            1: begin er = a / 2 + ci * 128; ec = a % 2; end
            2: begin er = (a * 2) % 256 + ci; ec = a / 128; end
            3: er = 255 - a;
            4: er = a & b;
            5: er = a | b;
            6: er = a ^ b;
            default: er = 0;
        endcase
        apply(op, a, b, ci);
        case (op)
            0: begin chk("R1 result", result, er); chk("R1 carry", carry_out, ec); end
            1: begin chk("R2 result", result, er); chk("R2 carry", carry_out, ec); end
            2: begin chk("R3 result", result, er); chk("R3 carry", carry_out, ec); end
            3: begin chk("R4 result", result, er); chk("R4 carry", carry_out, ec); end
            4, 5: begin chk("R5 result", result, er); chk("R5 carry", carry_out, ec); end
            6: begin chk("R6 result", result, er); chk("R6 carry", carry_out, ec); end
            default: begin chk("R7 result", result, er); chk("R7 carry", carry_out, ec); end
        endcase
        chk("R8 zero", zero_flag, (er == 0) ? 1 : 0);
        chk("R9 equal", equal_flag, (a == b) ? 1 : 0);
        chk("R10 larger", a_larger_flag, (a > b) ? 1 : 0);
    endtask

    int bset[20] = '{0, 1, 2, 127, 128, 129, 254, 255, 3, 15, 16, 31, 64, 85, 100, 170, 200, 240, 77, 191};

    initial begin
        logic [11:0] snap;
        op_sel = 3'b000; opnd_a = 8'd0; opnd_b = 8'd0; carry_in = 1'b0;
        // Initial state with all-zero inputs
        #2;
        chk("R1 idle result", result, 0);
        chk("R8 idle zero", zero_flag, 1);
        chk("R9 idle equal", equal_flag, 1);
        // Near-exhaustive sweep
        for (int op = 0; op < 8; op++)
            for (int a = 0; a < 256; a++)
                for (int bi = 0; bi < 20; bi++)
                    for (int ci = 0; ci < 2; ci++)
                        check_vec(op, a, bset[bi], ci);
        // Neighbour compares: A = B+1 and B = A+1
        for (int a = 1; a < 256; a++) begin
            check_vec(6, a, a - 1, 0);
            check_vec(0, a - 1, a, 1);
        end
        // R2/R3: B has no effect on shift result or carry
        for (int b = 0; b < 256; b++) begin
            apply(1, 8'hA5, b, 1);
            chk("R2 b-independent", {carry_out, result}, {1'b1, 8'hD2});
            apply(2, 8'hA5, b, 0);
            chk("R3 b-independent", {carry_out, result}, {1'b1, 8'h4A});
        end
        // R11: same inputs give same outputs after other traffic
        apply(0, 200, 100, 0);
        snap = {result, carry_out, zero_flag, equal_flag, a_larger_flag};
        apply(7, 255, 255, 1);
        apply(2, 128, 3, 1);
        apply(0, 200, 100, 0);
        chk("R11 repeat", {result, carry_out, zero_flag, equal_flag, a_larger_flag}, snap);
        chk("R11 value", {result, carry_out}, {8'd44, 1'b1});
        done = 1'b1;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (done || cyc >= 190000) begin
            if (!done) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: got %0d cycles expected completion", cyc);
            end
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule